// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer Bank

This block holds a bank of down-counting timers. Each channel has a period buffer and a compare buffer that software writes through a simple 32-bit register port. A channel counts only when its start bit is set. It steps once for each tick-enable pulse that a prescaler outside the block supplies. When a channel reaches zero it either reloads from its buffers or stops for good, depending on its auto-reload bit. The buffers are copied into the working registers only at a reload or while the channel's manual-update bit is held high. Software can therefore change a waveform without tearing the period that is in progress.

The first `PWM_CH` channels each drive one output pin. The output compares the live counter with the working compare value. The raw level is active-low, and a per-channel invert bit turns it into ordinary active-high PWM. The last channel is a plain timer: it has no pin and no invert control, and its auto-reload flag sits one bit lower in its control slot. A shared control word holds every channel's start, update, invert and auto-reload bits in 4-bit slots, with one empty slot after channel 0.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every control bit, buffer and working counter is zero, every register reads 0, and every PWM pin is high.
- R2: The control word is at 0x08. For channel c, the period buffer is at 0x0C+12c and the compare buffer is at 0x10+12c; both read back what was written. The live counter can be read at 0x14+12c, and writes to that address are ignored.
- R3: Channel 0 uses control bits 3:0, and channel c≥1 uses bits 4(c+1)+3:4(c+1). Within a slot, bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload. The timer-only channel keeps auto-reload in slot bit 2 and has no invert. Unused bits (7:4, 23, 31:24) are ignored on write and read 0; writing all ones reads back 0x007FFF0F.
- R4: For every cycle in which a channel's manual-update bit is 1, the channel's working counter and compare value are loaded from its buffers, and the channel does not count.
- R5: When start is 1 and manual update is 0, the counter drops by one on each cycle with its tick high. It holds on cycles with the tick low.
- R6: A tick at count zero reloads both working values from the buffers if auto-reload is 1. Otherwise the counter stays at zero and the channel halts until its next manual update or stop.
- R7: With period value N and compare value C (C < N), the raw output is low (active) for N−C of every N+1 ticks.
- R8: A compare value of 0xFFFFFFFF keeps the output active for the whole period.
- R9: Invert bit 0 gives the active-low raw level on the pin; invert bit 1 gives an active-high pin.
- R10: A stopped or halted channel drives its inactive level: 1 with invert clear, 0 with invert set.
- R11: Buffer writes made while a channel runs leave the period in progress unchanged and take effect at the next reload.
- R12: The timer-only channel (channel 4) counts and reloads from its own buffers and never changes any PWM pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| tick | input | NUM_CH | Per-channel count enable from the prescaler |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pwm_out | output | PWM_CH | PWM pins of the output channels |

## Verification
The hardest situation to reach from the ports is a buffer change landing in the middle of a running period. The bench rewrites a period buffer while the counter is counting. It then reads the live counter at once to confirm the old period continues, and reads it again after the next wrap to see the new value. A second hard case is the halt that follows clearing auto-reload. The bench reaches it by rewriting the control word while the channel counts, then confirms that the counter stays at zero and the pin sits at its inactive level. Duty cycles are checked by counting pin levels over a window that is an exact multiple of the period, so the result does not depend on the phase.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    // per-channel control fields, MSB first
    typedef struct packed {
        logic reload;
        logic invert;
        logic update;
        logic run;
    } chan_ctl_t;

    localparam int CTRL_OFS   = 'h08;
    localparam int GRP_BASE   = 'h0C;
    localparam int GRP_STRIDE = 12;

    // control-word slot of a channel: one empty slot follows channel 0
    function automatic int slot_of(input int ch);
        return (ch == 0) ? 0 : ch + 1;
    endfunction

    // byte address of word w (0 period, 1 compare, 2 live) of channel ch
    function automatic int grp_addr(input int ch, input int w);
        return GRP_BASE + GRP_STRIDE * ch + 4 * w;
    endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int PWM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [31:0]                      wdata,
    input  logic [NUM_CH-1:0][CNT_W-1:0]     live_cnt,
    output logic [31:0]                      rdata,
    output chan_ctl_t [NUM_CH-1:0]           ctl,
    output logic [NUM_CH-1:0][CNT_W-1:0]     cnt_buf,
    output logic [NUM_CH-1:0][CNT_W-1:0]     cmp_buf
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);

    logic                    ctl_wr;
    logic [NUM_CH-1:0][31:0] ctl_bits;
    logic [31:0]             ctl_word;

    assign ctl_wr = wr_en && (addr == A_CTRL);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int S = 4 * slot_of(c);
        localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(grp_addr(c, 0));
        localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(grp_addr(c, 1));

        chan_ctl_t        ctl_r;
        logic [CNT_W-1:0] cnt_r, cmp_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_r <= '0;
                cnt_r <= '0;
                cmp_r <= '0;
            end else begin
                if (ctl_wr) begin
                    ctl_r.run    <= wdata[S];
                    ctl_r.update <= wdata[S+1];
                    if (c < PWM_CH) begin
                        ctl_r.invert <= wdata[S+2];
                        ctl_r.reload <= wdata[S+3];
                    end else begin
                        ctl_r.invert <= 1'b0;
                        ctl_r.reload <= wdata[S+2];
                    end
                end
                if (wr_en && addr == A_CNT) cnt_r <= wdata[CNT_W-1:0];
                if (wr_en && addr == A_CMP) cmp_r <= wdata[CNT_W-1:0];
            end
        end

        assign ctl[c]     = ctl_r;
        assign cnt_buf[c] = cnt_r;
        assign cmp_buf[c] = cmp_r;

        if (c < PWM_CH) begin : g_pwm_slot
            assign ctl_bits[c] = 32'({ctl_r.reload, ctl_r.invert, ctl_r.update, ctl_r.run}) << S;
        end else begin : g_tmr_slot
            assign ctl_bits[c] = 32'({1'b0, ctl_r.reload, ctl_r.update, ctl_r.run}) << S;
        end
    end

    always_comb begin
        ctl_word = '0;
        for (int c = 0; c < NUM_CH; c++) ctl_word = ctl_word | ctl_bits[c];
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) rdata = ctl_word;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_W'(grp_addr(c, 0))) rdata = 32'(cnt_buf[c]);
            if (addr == ADDR_W'(grp_addr(c, 1))) rdata = 32'(cmp_buf[c]);
            if (addr == ADDR_W'(grp_addr(c, 2))) rdata = 32'(live_cnt[c]);
        end
    end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  chan_ctl_t        ctl,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             halted_q,
    output logic             pin
);
    localparam logic [CNT_W-1:0] FULL = '1;

    logic running, active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            cmp_q    <= '0;
            halted_q <= 1'b0;
        end else if (ctl.update) begin
            cnt_q    <= cnt_buf;
            cmp_q    <= cmp_buf;
            halted_q <= 1'b0;
        end else if (!ctl.run) begin
            halted_q <= 1'b0;
        end else if (tick && !halted_q) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (ctl.reload) begin
                cnt_q <= cnt_buf;
                cmp_q <= cmp_buf;
            end else begin
                halted_q <= 1'b1;
            end
        end
    end

    assign running = ctl.run && !halted_q;
    assign active  = running && ((cmp_q == FULL) || (cnt_q > cmp_q));
    // raw level is active-low; invert makes it active-high
    assign pin     = ctl.invert ? active : !active;

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int PWM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [NUM_CH-1:0] tick,
    output logic [31:0]       rdata,
    output logic [PWM_CH-1:0] pwm_out
);
    chan_ctl_t [NUM_CH-1:0]           ctl;
    logic [NUM_CH-1:0][CNT_W-1:0]     cnt_buf, cmp_buf, cnt_q, cmp_q;
    logic [NUM_CH-1:0]                halted, pin_all;

    pwm_bank_regs #(
        .NUM_CH(NUM_CH), .PWM_CH(PWM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .live_cnt(cnt_q), .rdata(rdata), .ctl(ctl),
        .cnt_buf(cnt_buf), .cmp_buf(cmp_buf)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        pwm_bank_chan #(.CNT_W(CNT_W)) chan_i (
            .clk(clk), .rst(rst), .ctl(ctl[c]), .tick(tick[c]),
            .cnt_buf(cnt_buf[c]), .cmp_buf(cmp_buf[c]),
            .cnt_q(cnt_q[c]), .cmp_q(cmp_q[c]),
            .halted_q(halted[c]), .pin(pin_all[c])
        );
    end

    for (genvar c = 0; c < PWM_CH; c++) begin : g_pin
        assign pwm_out[c] = pin_all[c];
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst,
    input chan_ctl_t [NUM_CH-1:0]       ctl,
    input logic [NUM_CH-1:0]            tick,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf,
    input logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_q,
    input logic [NUM_CH-1:0][CNT_W-1:0] cmp_q,
    input logic [NUM_CH-1:0]            halted,
    input logic [NUM_CH-1:0]            pin_all
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        logic stepping;
        assign stepping = ctl[c].run && !ctl[c].update && !halted[c] && tick[c];

        // R4
        manual_load_chk: assert property (@(posedge clk) disable iff (rst)
            ctl[c].update |=> (cnt_q[c] == $past(cnt_buf[c]) && cmp_q[c] == $past(cmp_buf[c])));

        // R5
        count_step_chk: assert property (@(posedge clk) disable iff (rst)
            (stepping && cnt_q[c] != '0) |=> cnt_q[c] == $past(cnt_q[c]) - 1'b1);

        // R5
        tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!ctl[c].update && !tick[c]) |=> $stable(cnt_q[c]));

        // R6
        reload_chk: assert property (@(posedge clk) disable iff (rst)
            (stepping && cnt_q[c] == '0 && ctl[c].reload) |=> cnt_q[c] == $past(cnt_buf[c]));

        // R6
        halt_chk: assert property (@(posedge clk) disable iff (rst)
            (stepping && cnt_q[c] == '0 && !ctl[c].reload) |=> (halted[c] && cnt_q[c] == '0));

        // R10
        idle_level_chk: assert property (@(posedge clk) disable iff (rst)
            (!ctl[c].run || halted[c]) |-> pin_all[c] == !ctl[c].invert);
    end
endmodule

bind pwm_timer_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .ctl(ctl), .tick(tick),
    .cnt_buf(cnt_buf), .cmp_buf(cmp_buf), .cnt_q(cnt_q), .cmp_q(cmp_q),
    .halted(halted), .pin_all(pin_all)
);

// File: tb/pwm_timer_bank_tb.sv
module pwm_timer_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [4:0]  tick = '1;
    logic [31:0] rdata;
    logic [3:0]  pwm_out;

    int total = 0;
    int fails = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    pwm_timer_bank dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .tick(tick), .rdata(rdata), .pwm_out(pwm_out)
    );

    // driver side: queue the expected value
    task automatic expect_val(input string tag, input logic [31:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // monitor side: pop and compare against what the design produced
    task automatic observe(input logic [31:0] act);
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", t, act, e);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // count cycles with pin ch at level lvl over n cycles
    task automatic measure(input int ch, input logic lvl, input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1 if (pwm_out[ch] == lvl) hits++;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        int hits;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1 expect_val("R1 pins after reset", 32'hF); observe(32'(pwm_out));
        rd(8'h08, v); expect_val("R1 control word after reset", 0); observe(v);
        rd(8'h14, v); expect_val("R1 live counter after reset", 0); observe(v);

        // R3 layout with all ones, unused bits read zero
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); expect_val("R3 control readback", 32'h007F_FF0F); observe(v);
        wr(8'h08, 32'h0);

        // R2 buffers and read-only live counter
        wr(8'h0C, 9); wr(8'h10, 3);
        rd(8'h0C, v); expect_val("R2 period buffer ch0", 9); observe(v);
        rd(8'h10, v); expect_val("R2 compare buffer ch0", 3); observe(v);
        wr(8'h14, 77);
        rd(8'h14, v); expect_val("R2 live counter ignores write", 0); observe(v);

        // R4 manual update loads live counter
        wr(8'h08, 32'h2); wr(8'h08, 32'h0);
        rd(8'h14, v); expect_val("R4 manual update load", 9); observe(v);
        expect_val("R10 stopped pin high", 1); observe(32'(pwm_out[0]));

        // R7 R9 invert on, auto-reload: active high for 6 of 10
        wr(8'h08, 32'hD);
        wait_cyc(12);
        measure(0, 1'b1, 100, hits);
        expect_val("R7 duty with invert", 60); observe(32'(hits));

        // R9 invert off: raw active-low
        wr(8'h08, 32'h9);
        wait_cyc(3);
        measure(0, 1'b0, 100, hits);
        expect_val("R9 raw active-low duty", 60); observe(32'(hits));

        // R11 buffer write while running
        wr(8'h08, 32'hD);
        wr(8'h0C, 200);
        rd(8'h14, v); expect_val("R11 current period kept", 1); observe(32'(v < 10));
        wait_cyc(20);
        rd(8'h14, v); expect_val("R11 new period after reload", 1); observe(32'(v > 9));

        // R8 full-period compare
        wr(8'h10, 32'hFFFF_FFFF);
        wait_cyc(210);
        measure(0, 1'b1, 50, hits);
        expect_val("R8 all-ones compare full duty", 50); observe(32'(hits));

        // R10 stopped with invert set -> low
        wr(8'h08, 32'h4);
        #1 expect_val("R10 stopped inverted pin low", 0); observe(32'(pwm_out[0]));

        // R3 channel 1 in slot 2 (bits 11:8)
        wr(8'h18, 4); wr(8'h1C, 1);
        wr(8'h08, 32'h200);
        #1 expect_val("R10 stopped pin high again", 1); observe(32'(pwm_out[0]));
        wr(8'h08, 32'hD00);
        wait_cyc(5);
        measure(1, 1'b1, 50, hits);
        expect_val("R3 ch1 slot mapping duty", 30); observe(32'(hits));

        // R5 tick low holds the counter
        @(negedge clk); tick[1] = 1'b0;
        rd(8'h20, v); wait_cyc(7); rd(8'h20, v2);
        expect_val("R5 hold without tick", v); observe(v2);
        @(negedge clk); tick[1] = 1'b1;

        // R6 clear auto-reload -> halts at zero
        wr(8'h08, 32'h500);
        wait_cyc(12);
        rd(8'h20, v); expect_val("R6 halted at zero", 0); observe(v);
        #1 expect_val("R10 halted inverted pin low", 0); observe(32'(pwm_out[1]));
        wait_cyc(10);
        rd(8'h20, v); expect_val("R6 stays halted", 0); observe(v);

        // R12 timer-only channel, auto-reload in slot bit 2
        wr(8'h3C, 3); wr(8'h40, 0);
        wr(8'h08, 32'h0020_0000);
        wr(8'h08, 32'h0050_0000);
        wait_cyc(9);
        rd(8'h44, v); rd(8'h44, v2);
        expect_val("R12 ch4 keeps counting", 1); observe(32'(v != v2 && v <= 3 && v2 <= 3));
        #1 expect_val("R12 no pin moves", 32'hF); observe(32'(pwm_out));

        // R3 bit 23 is not a control bit for ch4
        wr(8'h08, 32'h00D0_0000);
        rd(8'h08, v); expect_val("R3 bit 23 ignored", 32'h0050_0000); observe(v);

        // R6 ch4 without auto-reload halts
        wr(8'h08, 32'h0010_0000);
        wait_cyc(10);
        rd(8'h44, v); expect_val("R6 ch4 halts at zero", 0); observe(v);

        finish_run();
    end
endmodule